// File: doc/BRIEF.md
# Gated Down Counter with Compare

This block is an 8-bit programmable down counter. It is set up through a small register port: a period value, a compare value, and a control word. The control word holds an enable bit, an interrupt-source select and a compare-type select. While the block is enabled and the gate input is high, the count moves down by one on every clock. After the count reaches zero, the next gated clock loads the period value again. When the gate input is low, the count freezes, and a reload that is due also waits.

The live count is compared with the compare value to drive the primary output. The terminal-count pulse drives the auxiliary output. A single interrupt request is a one-cycle pulse, raised on the rising edge of whichever source is selected: terminal count or compare.

Software prepares the counter while it is disabled. Writing the period also presets the count. A read of the count register while the block is disabled copies the live count into the compare register, which lets software snapshot the count.

Top module: `gated_down_counter`

## Requirements
- R1: After reset, the count, period, compare and control registers all read 0, and cmp_out, tc_out and irq are low.
- R2: While disabled, a write to the period register (address 1) also loads the count register (address 0) on the same edge. The count never changes otherwise while disabled, and writes to address 0 are ignored.
- R3: While enabled (control bit 0 = 1) with gate high, the count falls by one per clock. When the count is 0, the next clock loads the period value.
- R4: While enabled with gate low, the count holds its value, including a pending reload from 0.
- R5: tc_out is high exactly when the block is enabled, gate is high and the count is 0.
- R6: cmp_out is high when enabled and count <= compare (control bit 2 = 0), or when enabled and count < compare (control bit 2 = 1). The compare register is at address 2.
- R7: irq is a one-cycle pulse in the cycle after the selected source goes from 0 to 1. The source is tc_out when control bit 1 = 0 and cmp_out when control bit 1 = 1. irq never stays high for two cycles in a row.
- R8: A read strobe on address 0 while the block is disabled copies the count into the compare register, visible at address 2 from the next cycle.
- R9: A read strobe on address 0 while the block is enabled leaves the compare register unchanged.
- R10: While disabled, cmp_out, tc_out and irq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 count, 1 period, 2 compare, 3 control |
| wr_data | input | 8 | Write data; control uses bits 2:0 |
| rd_en | input | 1 | Read strobe; on address 0 it triggers the snapshot |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| gate | input | 1 | Counting gate; low halts counting and reload |
| cmp_out | output | 1 | Primary output: compare result |
| tc_out | output | 1 | Auxiliary output: terminal count |
| irq | output | 1 | Interrupt request pulse |

## Verification
A wrong count shows up on the same clock in three places: rd_data at address 0, the compare output, and the terminal-count output. This is because both outputs are decoded combinationally from the count register. A lost or doubled reload shifts every later terminal-count pulse, so the bench's per-clock model exposes it within one period. A bad edge-detect register shows as a missing, late or doubled irq one cycle after the source rises. A bad snapshot path shows at address 2 on the cycle after the read strobe.

// File: rtl/gdc_pkg.sv
// Shared types for the gated down counter.
// Assumes a 2-bit register address space.
package gdc_pkg;
    typedef enum logic [1:0] {
        ADDR_COUNT   = 2'd0,
        ADDR_PERIOD  = 2'd1,
        ADDR_COMPARE = 2'd2,
        ADDR_CTRL    = 2'd3
    } gdc_addr_e;

    typedef struct packed {
        logic lt_mode;     // bit 2: strict less-than compare
        logic irq_on_cmp;  // bit 1: interrupt source is compare
        logic enable;      // bit 0: counter running
    } gdc_ctrl_t;

    localparam int CTRL_BITS = $bits(gdc_ctrl_t);
endpackage

// File: rtl/gdc_regs.sv
// Register file: holds period, compare and control.
// Generates the preload strobe (period write while disabled).
// Performs the count-to-compare snapshot on a disabled read.
// Assumes WIDTH >= CTRL_BITS.
module gdc_regs
    import gdc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] cnt,
    output logic [WIDTH-1:0] period,
    output logic [WIDTH-1:0] cmp_val,
    output gdc_ctrl_t        ctrl,
    output logic             preload
);
    logic snap;
    logic cmp_wr;

    // Decode the snapshot, compare-write and preload strobes.
    always_comb begin
        snap    = rd_en && (rd_addr == ADDR_COUNT) && !ctrl.enable;
        cmp_wr  = wr_en && (wr_addr == ADDR_COMPARE);
        preload = wr_en && (wr_addr == ADDR_PERIOD) && !ctrl.enable;
    end

    // Update the stored registers; a direct compare write wins over a snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period  <= '0;
            cmp_val <= '0;
            ctrl    <= '0;
        end else begin
            if (snap)
                cmp_val <= cnt;
            if (wr_en) begin
                case (wr_addr)
                    ADDR_PERIOD:  period  <= wr_data;
                    ADDR_COMPARE: cmp_val <= wr_data;
                    ADDR_CTRL:    ctrl    <= gdc_ctrl_t'(wr_data[CTRL_BITS-1:0]);
                    default:      ;
                endcase
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        case (rd_addr)
            ADDR_COUNT:   rd_data = cnt;
            ADDR_PERIOD:  rd_data = period;
            ADDR_COMPARE: rd_data = cmp_val;
            default:      rd_data = {{(WIDTH-CTRL_BITS){1'b0}}, ctrl};
        endcase
    end

    assert_snap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_COUNT && !ctrl.enable && !cmp_wr)
            |=> (cmp_val == $past(cnt)));

    assert_nosnap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctrl.enable && !cmp_wr) |=> $stable(cmp_val));
endmodule

// File: rtl/gdc_count.sv
// Count register with gated decrement and reload.
// Decodes terminal count and the compare result from the count.
// Assumes preload is only asserted while disabled.
module gdc_count #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             gate,
    input  logic             lt_mode,
    input  logic             preload,
    input  logic [WIDTH-1:0] preload_val,
    input  logic [WIDTH-1:0] period,
    input  logic [WIDTH-1:0] cmp_val,
    output logic [WIDTH-1:0] cnt,
    output logic             tc,
    output logic             cmp_hit
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    // Advance, reload or preset the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (preload)
            cnt <= preload_val;
        else if (en && gate)
            cnt <= (cnt == ZERO) ? period : cnt - ONE;
    end

    // Terminal count and selectable inequality, both gated by enable.
    always_comb begin
        tc      = en && gate && (cnt == ZERO);
        cmp_hit = en && (lt_mode ? (cnt < cmp_val) : (cnt <= cmp_val));
    end

    assert_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && gate && cnt != ZERO) |=> (cnt == $past(cnt) - ONE));

    assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && gate && cnt == ZERO) |=> (cnt == $past(period)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !gate) |=> $stable(cnt));
endmodule

// File: rtl/gdc_irq.sv
// Interrupt pulse generator.
// Selects terminal count or compare as the source, registers it,
// and emits a one-cycle pulse on its rising edge.
// Assumes both sources are already low while disabled.
module gdc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sel_cmp,
    input  logic tc,
    input  logic cmp_hit,
    output logic irq
);
    logic src;
    logic src_d;
    logic pulse_q;

    // Choose the interrupt source.
    always_comb src = sel_cmp ? cmp_hit : tc;

    // Register the source and latch its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_d   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            src_d   <= src;
            pulse_q <= src && !src_d;
        end
    end

    // Gate the pulse with enable.
    always_comb irq = pulse_q && en;

    assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

// File: rtl/gated_down_counter.sv
// Top level: 8-bit gated down counter with compare and selectable interrupt.
// Wires the register file, the count core and the interrupt generator.
module gated_down_counter
    import gdc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             gate,
    output logic             cmp_out,
    output logic             tc_out,
    output logic             irq
);
    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] period;
    logic [WIDTH-1:0] cmp_val;
    gdc_ctrl_t        ctrl;
    logic             preload;

    gdc_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cnt     (cnt),
        .period  (period),
        .cmp_val (cmp_val),
        .ctrl    (ctrl),
        .preload (preload)
    );

    gdc_count #(.WIDTH(WIDTH)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl.enable),
        .gate        (gate),
        .lt_mode     (ctrl.lt_mode),
        .preload     (preload),
        .preload_val (wr_data),
        .period      (period),
        .cmp_val     (cmp_val),
        .cnt         (cnt),
        .tc          (tc_out),
        .cmp_hit     (cmp_out)
    );

    gdc_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.enable),
        .sel_cmp (ctrl.irq_on_cmp),
        .tc      (tc_out),
        .cmp_hit (cmp_out),
        .irq     (irq)
    );

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.enable |-> (!cmp_out && !tc_out && !irq));
endmodule

// File: tb/sim_gated_down_counter.sv
module sim_gated_down_counter;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       gate = 1'b0;
    logic       cmp_out, tc_out, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_cnt = 0, m_per = 0, m_cmp = 0;
    bit m_en = 0, m_sel = 0, m_lt = 0, m_srcd = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    gated_down_counter #(.WIDTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .gate(gate), .cmp_out(cmp_out),
        .tc_out(tc_out), .irq(irq)
    );

    function automatic bit e_tc();
        return m_en && gate && (m_cnt == 0);
    endfunction

    function automatic bit e_cmp();
        return m_en && (m_lt ? (m_cnt < m_cmp) : (m_cnt <= m_cmp));
    endfunction

    function automatic int e_rd();
        case (rd_addr)
            2'd0: return m_cnt;
            2'd1: return m_per;
            2'd2: return m_cmp;
            default: return {m_lt, m_sel, m_en};
        endcase
    endfunction

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_cmp = 0;
            m_en = 0; m_sel = 0; m_lt = 0; m_srcd = 0; m_irq = 0;
        end else begin
            bit src;
            int n_cnt, n_cmp;
            src = m_sel ? e_cmp() : e_tc();
            n_cnt = m_cnt;
            n_cmp = m_cmp;
            if (m_en && gate) n_cnt = (m_cnt == 0) ? m_per : m_cnt - 1;
            if (rd_en && rd_addr == 2'd0 && !m_en) n_cmp = m_cnt;
            if (wr_en) begin
                case (wr_addr)
                    2'd1: begin
                        if (!m_en) n_cnt = wr_data;
                        m_per = wr_data;
                    end
                    2'd2: n_cmp = wr_data;
                    2'd3: begin
                        m_en = wr_data[0]; m_sel = wr_data[1]; m_lt = wr_data[2];
                    end
                    default: ;
                endcase
            end
            m_irq = src && !m_srcd;
            m_srcd = src;
            m_cnt = n_cnt;
            m_cmp = n_cmp;
        end
    end

    // per-clock comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 R4 rd_data", rd_data, e_rd());
            check("R5 tc_out", tc_out, e_tc());
            check("R6 cmp_out", cmp_out, e_cmp());
            check("R7 irq", irq, m_irq && m_en);
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a);
        rd_addr = a; #0.2;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5.0);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int held;
        int snapv;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            peek(2'(a));
            check("R1 register after reset", rd_data, 0);
        end
        check("R1 cmp_out after reset", cmp_out, 0);
        check("R1 tc_out after reset", tc_out, 0);
        check("R1 irq after reset", irq, 0);
        idle(1);

        // R2: preload while disabled, count register not writable
        wr(2'd1, 8'd5);
        peek(2'd0);
        check("R2 preload from period", rd_data, 5);
        wr(2'd0, 8'h33);
        peek(2'd0);
        check("R2 count write ignored", rd_data, 5);
        idle(2);

        // R10: disabled keeps outputs quiet
        check("R10 outputs low while disabled", {cmp_out, tc_out, irq}, 0);

        // R3 R5 R6 R7: run with <= compare, interrupt on terminal count
        wr(2'd2, 8'd2);
        wr(2'd3, 8'b001);
        gate = 1'b1;
        peek(2'd0);
        idle(20);

        // R4: irregular gate, including hold at zero
        for (int i = 0; i < 30; i++) begin
            gate = (i % 3) != 0;
            idle(1);
        end
        gate = 1'b0;
        peek(2'd0);
        held = rd_data;
        idle(3);
        peek(2'd0);
        check("R4 count held with gate low", rd_data, held);
        gate = 1'b1;

        // R6 R7: strict compare, interrupt on compare
        wr(2'd3, 8'b111);
        idle(20);

        // R9: read strobe while enabled leaves compare alone
        rd_en = 1'b1; rd_addr = 2'd0;
        idle(1);
        rd_en = 1'b0;
        peek(2'd2);
        check("R9 compare unchanged by enabled read", rd_data, 2);

        // R10 then R8: disable, snapshot the count
        wr(2'd3, 8'b000);
        check("R10 quiet after disable", {cmp_out, tc_out, irq}, 0);
        peek(2'd0);
        snapv = rd_data;
        rd_en = 1'b1;
        idle(1);
        rd_en = 1'b0;
        peek(2'd2);
        check("R8 snapshot into compare", rd_data, snapv);

        // R5 R7: zero period keeps terminal count high, one interrupt only
        wr(2'd1, 8'd0);
        wr(2'd3, 8'b001);
        peek(2'd0);
        idle(6);
        check("R5 tc_out held with zero period", tc_out, 1);
        check("R7 no repeat interrupt", irq, 0);

        // full-range period with strict compare near the top
        wr(2'd3, 8'b000);
        wr(2'd1, 8'd255);
        wr(2'd2, 8'd254);
        wr(2'd3, 8'b101);
        idle(600);
        finish_run();
    end
endmodule